// File: doc/BRIEF.md
# Shared-Line Interrupt Aggregator

This block gathers a wide set of peripheral interrupt sources onto a small number of shared CPU interrupt lines. Every source position has a pending bit. The pending bits sit in a few 32-bit status words. A rising edge on a source sets its pending bit, and the bit stays set until software clears it by writing a one to the matching clear word. Each output line has its own enable area, with one enable word for each status word. A line is active when any pending bit is also enabled in that line's area, and when the line's master gate is set. The master gate is bit 0 of enable word 0 of that line. That bit position is never a source.

Each line is given out as a registered level and as a one-cycle pulse on the level's rising edge. A handler running on an edge-sensitive CPU input can request a new edge for sources that are still pending. It does this by dropping the line's master gate and raising it again. Software decides which sources go to which line and in what priority. The block itself only keeps the enable maps.

A simple word-addressed register bus gives access to the words. The status words come first, then the clear words, then one block of enable words for each line.

Top module: `shared_irq_aggregator`

## Requirements
- R1: A source input that is low at one clock edge and high at the next sets its pending bit at that second edge. The status word reads return the raw pending bits whatever the enables are. Source input bit 0 is ignored, so status bit 0 of word 0 always reads 0. Source bit k of `src_i` maps to status word k/32, bit k%32.
- R2: A pending bit whose enables are clear stays set. If an enable for it is set later, the line asserts.
- R3: A write to clear word w clears the pending bits at the positions written as one and leaves the positions written as zero unchanged. Reads of clear words return 0. Writes to status words have no effect.
- R4: If a source sets a pending bit in the same cycle as a clear write to that bit, the bit ends up set.
- R5: Line l's level, one clock after the inputs to it change, is the master gate of line l ANDed with the OR of (status & enables of line l) over all words. Each line uses only its own enable words.
- R6: Clearing and then setting a line's master gate while enabled sources remain pending drops the level and then raises it again, with a new pulse.
- R7: After zero is written to every enable word, all line levels are 0 and the pending bits are unchanged.
- R8: `irq_pulse[l]` is high for exactly the one cycle in which `irq_level[l]` has just gone from 0 to 1. Reset clears all pending bits, all enables, all levels and all pulses.
- R9: The bus uses word addresses. Status word w is at w. Clear word w is at NW+w. The enable word w of line l is at 2*NW + l*NW + w. With the defaults (NW=2, NL=4) the enable words are at 4..11. Enable words read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NW*32 | Source inputs, sampled on the clock; bit 0 is unused |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_level | output | NL | Registered level of each shared line |
| irq_pulse | output | NL | One-cycle pulse on the rising edge of each line |

## Verification
The assertions assume that the bus performs at most one write per cycle, and that a write to a clear word is the only way a pending bit can fall. They also assume that sources are sampled only on the clock, so one edge detect per cycle is enough. The stimulus changes the sources and the bus signals only on the falling clock edge. It always returns a source to zero before it raises that source again, so every intended rising edge is seen. The same-cycle set and clear case is driven on purpose, as a single cycle in which both happen.

// File: rtl/aggr_pkg.sv
package aggr_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {RG_STATUS, RG_CLEAR, RG_ENABLE, RG_NONE} rgn_e;

  typedef struct packed {
    rgn_e        rgn;
    logic [7:0]  line;
    logic [7:0]  word;
  } dec_t;

  // Word address to region, line and word index.
  function automatic dec_t decode(int unsigned a, int unsigned nw, int unsigned nl);
    dec_t d;
    int unsigned off;
    d = '{rgn: RG_NONE, line: 8'd0, word: 8'd0};
    if (a < nw) begin
      d.rgn  = RG_STATUS;
      d.word = 8'(a);
    end else if (a < 2 * nw) begin
      d.rgn  = RG_CLEAR;
      d.word = 8'(a - nw);
    end else if (a < (2 + nl) * nw) begin
      off    = a - 2 * nw;
      d.rgn  = RG_ENABLE;
      d.line = 8'(off / nw);
      d.word = 8'(off % nw);
    end
    return d;
  endfunction

  // Next pending state: sets win over clears.
  function automatic logic [WORD_W-1:0] next_pend(logic [WORD_W-1:0] cur,
                                                   logic [WORD_W-1:0] set,
                                                   logic [WORD_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/aggr_pending.sv
module aggr_pending
  import aggr_pkg::*;
#(
  parameter int NW = 2,
  localparam int NB = NW * WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] src_i,
  input  logic [NB-1:0] clr_i,
  output logic [NB-1:0] status_o,
  output logic [NB-1:0] set_o
);
  localparam logic [NB-1:0] SRC_MASK = {{(NB-1){1'b1}}, 1'b0};

  logic [NB-1:0] src_q;
  logic [NB-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_i & SRC_MASK;
  end

  assign set_o = (src_i & SRC_MASK) & ~src_q;

  for (genvar w = 0; w < NW; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend_q[w*WORD_W +: WORD_W] <= '0;
      else
        pend_q[w*WORD_W +: WORD_W] <= next_pend(pend_q[w*WORD_W +: WORD_W],
                                                set_o[w*WORD_W +: WORD_W],
                                                clr_i[w*WORD_W +: WORD_W]);
    end
  end

  assign status_o = pend_q;
endmodule

// File: rtl/aggr_enable_bank.sv
module aggr_enable_bank
  import aggr_pkg::*;
#(
  parameter int NW = 2,
  parameter int NL = 4,
  localparam int NB = NW * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NL*NW-1:0]  we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [NL*NB-1:0]  en_o
);
  logic [NL*NB-1:0] en_q;

  for (genvar i = 0; i < NL * NW; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q[i*WORD_W +: WORD_W] <= '0;
      else if (we_i[i]) en_q[i*WORD_W +: WORD_W] <= wdata_i;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/aggr_line_drive.sv
module aggr_line_drive
  import aggr_pkg::*;
#(
  parameter int NW = 2,
  localparam int NB = NW * WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] status_i,
  input  logic [NB-1:0] en_i,
  output logic          active_o,
  output logic          level_o,
  output logic          pulse_o
);
  logic gate;
  logic level_q;
  logic pulse_q;

  assign gate     = en_i[0];
  assign active_o = gate & (|(status_i & en_i & {{(NB-1){1'b1}}, 1'b0}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      level_q <= active_o;
      pulse_q <= active_o & ~level_q;
    end
  end

  assign level_o = level_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/shared_irq_aggregator.sv
module shared_irq_aggregator
  import aggr_pkg::*;
#(
  parameter  int NW = 2,
  parameter  int NL = 4,
  localparam int NB = NW * WORD_W,
  localparam int AW = $clog2(NW * (2 + NL))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     src_i,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [NL-1:0]     irq_level,
  output logic [NL-1:0]     irq_pulse
);
  dec_t              dec;
  logic [NB-1:0]     status;
  logic [NB-1:0]     set_vec;
  logic [NB-1:0]     clr_vec;
  logic [NL*NW-1:0]  en_we;
  logic [NL*NB-1:0]  en_flat;
  logic [NL-1:0]     line_active;
  logic              rd_is_clear;

  assign dec         = decode(int'(bus_addr), NW, NL);
  assign rd_is_clear = (dec.rgn == RG_CLEAR);

  for (genvar w = 0; w < NW; w++) begin : g_clr
    assign clr_vec[w*WORD_W +: WORD_W] =
      (bus_we && dec.rgn == RG_CLEAR && int'(dec.word) == w) ? bus_wdata : '0;
  end

  for (genvar l = 0; l < NL; l++) begin : g_we
    for (genvar w = 0; w < NW; w++) begin : g_w
      assign en_we[l*NW + w] = bus_we && dec.rgn == RG_ENABLE &&
                               int'(dec.line) == l && int'(dec.word) == w;
    end
  end

  aggr_pending #(.NW(NW)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .clr_i(clr_vec),
    .status_o(status), .set_o(set_vec)
  );

  aggr_enable_bank #(.NW(NW), .NL(NL)) u_en (
    .clk(clk), .rst_n(rst_n), .we_i(en_we), .wdata_i(bus_wdata), .en_o(en_flat)
  );

  for (genvar l = 0; l < NL; l++) begin : g_line
    aggr_line_drive #(.NW(NW)) u_drv (
      .clk(clk), .rst_n(rst_n), .status_i(status),
      .en_i(en_flat[l*NB +: NB]), .active_o(line_active[l]),
      .level_o(irq_level[l]), .pulse_o(irq_pulse[l])
    );
  end

  always_comb begin
    bus_rdata = '0;
    unique case (dec.rgn)
      RG_STATUS: bus_rdata = status[int'(dec.word)*WORD_W +: WORD_W];
      RG_ENABLE: bus_rdata = en_flat[(int'(dec.line)*NW + int'(dec.word))*WORD_W +: WORD_W];
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/shared_irq_aggregator_chk.sv
module shared_irq_aggregator_chk #(
  parameter int NW = 2,
  parameter int NL = 4,
  localparam int NB = NW * 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NB-1:0]    status,
  input logic [NB-1:0]    set_vec,
  input logic [NB-1:0]    clr_vec,
  input logic [NL*NB-1:0] en_flat,
  input logic [NL-1:0]    irq_level,
  input logic [NL-1:0]    irq_pulse,
  input logic             rd_is_clear,
  input logic [31:0]      bus_rdata
);
  // R3: no pending bit falls without a clear write to it
  a_r3_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~$past(clr_vec)) & ~status) == '0));

  // R3: clear words read as zero
  a_r3_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_is_clear |-> (bus_rdata == 32'd0));

  // R4: a detected set is present next cycle even with a clear
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(set_vec)) == $past(set_vec)));

  for (genvar l = 0; l < NL; l++) begin : g_l
    // R8: pulse only on the first cycle of a high level
    a_r8_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse[l] |-> (irq_level[l] && !$past(irq_level[l])));
    // R5: master gate clear forces the line low one cycle later
    a_r5_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !en_flat[l*NB] |=> !irq_level[l]);
    // R7: an all-zero enable area silences the line
    a_r7_zero_enables_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (en_flat[l*NB +: NB] == '0) |=> !irq_level[l]);
  end
endmodule

bind shared_irq_aggregator shared_irq_aggregator_chk #(.NW(NW), .NL(NL)) u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .set_vec(set_vec),
  .clr_vec(clr_vec), .en_flat(en_flat), .irq_level(irq_level),
  .irq_pulse(irq_pulse), .rd_is_clear(rd_is_clear), .bus_rdata(bus_rdata)
);

// File: tb/shared_irq_aggregator_test.sv
`timescale 1ns/1ps
module shared_irq_aggregator_test;
  localparam int NW = 2;
  localparam int NL = 4;
  localparam int NB = NW * 32;
  localparam int AW = $clog2(NW * (2 + NL));

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] src_i = '0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_level;
  logic [NL-1:0] irq_pulse;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  shared_irq_aggregator #(.NW(NW), .NL(NL)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_level(irq_level), .irq_pulse(irq_pulse)
  );

  // Vector: source word 0, line 0 enable word 0, expected status word 0, expected level
  typedef struct packed {
    logic [31:0] src;
    logic [31:0] en;
    logic [31:0] st;
    logic        lvl;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0010, 32'h0000_0011, 32'h0000_0010, 1'b1},
    '{32'h0000_0010, 32'h0000_0010, 32'h0000_0010, 1'b0},
    '{32'h0000_0100, 32'h0000_0011, 32'h0000_0100, 1'b0},
    '{32'h8000_0001, 32'h8000_0001, 32'h8000_0000, 1'b1},
    '{32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    '{32'h0000_FF00, 32'h0000_0101, 32'h0000_FF00, 1'b1}
  };

  // Address helpers, restated from R9
  function automatic logic [AW-1:0] a_stat(int w);         return AW'(w);                endfunction
  function automatic logic [AW-1:0] a_clr(int w);          return AW'(NW + w);           endfunction
  function automatic logic [AW-1:0] a_en(int l, int w);    return AW'(2*NW + l*NW + w);  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic pulse_src(logic [NB-1:0] s);
    @(negedge clk);
    src_i = s;
    @(negedge clk);
    src_i = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: reset state
    @(negedge clk);
    check("R8 reset level", 32'(irq_level), 32'd0);
    check("R8 reset pulse", 32'(irq_pulse), 32'd0);
    rd(a_stat(0), rv); check("R8 reset status", rv, 32'd0);
    rd(a_en(2, 1), rv); check("R8 reset enable", rv, 32'd0);

    // Table walk on line 0 (R1, R5)
    for (int i = 0; i < 6; i++) begin
      wr(a_clr(0), 32'hFFFF_FFFF);
      wr(a_en(0, 0), VECS[i].en);
      pulse_src({32'h0, VECS[i].src});
      @(negedge clk);
      check("R5 table level", 32'(irq_level[0]), 32'(VECS[i].lvl));
      rd(a_stat(0), rv);
      check("R1 table status", rv, VECS[i].st);
    end
    wr(a_clr(0), 32'hFFFF_FFFF);

    // R2: pending held while disabled, asserts when enabled
    pulse_src(NB'(1) << 40);
    @(negedge clk);
    check("R2 disabled level", 32'(irq_level[1]), 32'd0);
    rd(a_stat(1), rv); check("R1 raw status word1", rv, 32'h0000_0100);
    wr(a_en(1, 1), 32'h0000_0100);
    wr(a_en(1, 0), 32'h0000_0001);
    @(negedge clk);
    check("R2 enabled level", 32'(irq_level[1]), 32'd1);
    check("R8 pulse on rise", 32'(irq_pulse[1]), 32'd1);
    @(negedge clk);
    check("R8 pulse one cycle", 32'(irq_pulse[1]), 32'd0);
    check("R5 other lines idle", 32'(irq_level & 4'b1101), 32'd0);

    // R6: master gate toggle gives a new edge
    wr(a_en(1, 0), 32'h0);
    @(negedge clk);
    check("R6 gate off level", 32'(irq_level[1]), 32'd0);
    wr(a_en(1, 0), 32'h1);
    @(negedge clk);
    check("R6 new pulse", 32'(irq_pulse[1]), 32'd1);
    check("R6 level back", 32'(irq_level[1]), 32'd1);

    // R3: write-one-to-clear semantics
    wr(a_clr(1), 32'h0);
    rd(a_stat(1), rv); check("R3 zero write keeps", rv, 32'h0000_0100);
    wr(a_stat(1), 32'h0);
    rd(a_stat(1), rv); check("R3 status write ignored", rv, 32'h0000_0100);
    rd(a_clr(1), rv); check("R3 clear reads zero", rv, 32'h0);
    wr(a_clr(1), 32'h0000_0100);
    @(negedge clk);
    check("R3 cleared level", 32'(irq_level[1]), 32'd0);
    rd(a_stat(1), rv); check("R3 cleared status", rv, 32'h0);

    // R4: set and clear in the same cycle
    @(negedge clk);
    src_i = NB'(1) << 40;
    bus_addr = a_clr(1); bus_wdata = 32'h0000_0100; bus_we = 1'b1;
    @(negedge clk);
    src_i = '0; bus_we = 1'b0;
    rd(a_stat(1), rv); check("R4 set wins", rv, 32'h0000_0100);

    // R7: zero all enables
    for (int l = 0; l < NL; l++)
      for (int w = 0; w < NW; w++)
        wr(a_en(l, w), 32'h0);
    @(negedge clk);
    check("R7 all silent", 32'(irq_level), 32'd0);
    rd(a_stat(1), rv); check("R7 status kept", rv, 32'h0000_0100);

    // R9: enable address map for the last line
    wr(a_en(3, 1), 32'h0000_0100);
    wr(a_en(3, 0), 32'h0000_0001);
    @(negedge clk);
    check("R9 line3 level", 32'(irq_level), 32'b1000);
    rd(AW'(11), rv); check("R9 enable readback", rv, 32'h0000_0100);

    finish_run();
  end
endmodule